// File: doc/BRIEF.md
# Segmented RAM Write Splitter

This block takes one byte-addressed write request and spreads it over a RAM built from several segments that sit side by side. Each segment is one word wide and holds a fixed number of bytes. Consecutive segment-sized chunks of the byte address space belong to consecutive segments, wrapping around. A request carries a start byte address, a byte count and the packed bytes, with byte 0 in the low eight bits. The block shifts the bytes so that each one lands on its byte lane. It then issues one word write per touched segment chunk. It starts in the segment that holds the first byte and moves to the next segment for each word after that.

Each segment has its own command port with a valid/ready handshake, a word address, data and byte enables. A command that is waiting for acceptance holds all of its fields steady until the segment raises ready. Segments accept their commands independently of one another. Each segment returns a one-cycle pulse for every write it finishes. The block counts these pulses and raises a one-cycle completion pulse once every issued word has been confirmed.

The request side has a valid/ready handshake. Ready is high only while no request is in progress. A request is rejected with a one-cycle error pulse, and issues no command, in any of these cases:
- its length is zero;
- its length is larger than the packed data can hold;
- it runs past the end of the address space.

Top module: `segwr_top`

## Requirements
- R1: `req_ready_o` is high exactly when no request is in progress. It goes low in the cycle after a valid request is accepted and returns high together with the completion or error pulse. While it is high, no segment command is pending.
- R2: A request with length 0, with length above MAX_BYTES, or with address + length above 2^ADDR_W raises `err_o` for one cycle, the cycle after acceptance. No segment command is issued for it.
- R3: With offset = address mod SEG_BYTES, the request needs ceil((length + offset) / SEG_BYTES) word writes. Write k goes to segment ((address / SEG_BYTES) + k) mod SEGS. Within a segment, writes appear in the order of k.
- R4: The word address of write k is (address + k·SEG_BYTES) / (SEGS·SEG_BYTES). It is carried on bits [s·SEG_AW +: SEG_AW] of `cmd_addr_o` for segment s.
- R5: Byte enable bit b of segment s is bit s·SEG_BYTES+b of `cmd_be_o`. The first write enables only lanes b ≥ offset. The last write enables only lanes b < ((address + length − 1) mod SEG_BYTES) + 1. A single-write request enables the lanes that satisfy both limits. Writes in between enable every lane.
- R6: Request byte j (bits [8j +: 8] of `req_data_i`) appears on byte lane (offset + j) mod SEG_BYTES of write (offset + j) / SEG_BYTES. After a request, every byte in the range holds the new value and every other byte is unchanged.
- R7: While a segment's valid is high and its ready is low, that segment's valid, address, data and byte enables stay unchanged in the next cycle.
- R8: `done_o` pulses for one cycle, in the cycle after the clock edge where the number of `wr_done_i` pulses received for the request reaches the number of writes issued. It never pulses earlier.
- R9: While `rst_i` is high, all segment valids, `done_o` and `err_o` are low from the next clock edge on. After reset, `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Number of bytes to write |
| req_data_i | input | MAX_BYTES·8 | Packed request bytes, byte 0 lowest |
| done_o | output | 1 | One-cycle pulse: all writes of the request confirmed |
| err_o | output | 1 | One-cycle pulse: request rejected |
| cmd_valid_o | output | SEGS | Per-segment command valid |
| cmd_ready_i | input | SEGS | Per-segment command ready |
| cmd_addr_o | output | SEGS·SEG_AW | Per-segment word address |
| cmd_data_o | output | SEGS·SEG_BYTES·8 | Per-segment write data |
| cmd_be_o | output | SEGS·SEG_BYTES | Per-segment byte enables |
| wr_done_i | input | SEGS | Per-segment one-cycle write-confirm pulse |

## Verification
Timing after an accepted request:
- The first segment command becomes visible one cycle after acceptance.
- Each later write appears one cycle after the previous one, as long as its target segment's holding register is free.
- The error pulse and the drop of `req_ready_o` are both due one cycle after acceptance.
- The completion pulse is due one cycle after the edge that samples the last confirm pulse.

How the bench keeps to this:
- It drives every input and samples every output at the falling clock edge.
- It evaluates a handshake from the valid and ready levels present before the rising edge that takes it.
- It raises the confirm pulse at the falling edge after that acceptance edge.
- At the falling edge where completion is first seen, it requires the number of confirms sent for the request to equal the number of writes expected.

// File: rtl/segwr_pkg.sv
package segwr_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } segwr_state_e;

endpackage

// File: rtl/segwr_align.sv
// Places request byte j at stream position off + j and marks the live positions.
module segwr_align #(
  parameter int MAX_BYTES = 16,
  parameter int STREAM_B  = 20,
  parameter int OFF_W     = 2,
  parameter int LEN_W     = 5
) (
  input  logic [MAX_BYTES*8-1:0] data_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic [LEN_W-1:0]       len_i,
  output logic [STREAM_B*8-1:0]  bytes_o,
  output logic [STREAM_B-1:0]    mask_o
);

  always_comb begin
    int rel;
    bytes_o = '0;
    mask_o  = '0;
    for (int p = 0; p < STREAM_B; p++) begin
      rel       = p - int'(off_i);
      mask_o[p] = (rel >= 0) && (rel < int'(len_i));
      if ((rel >= 0) && (rel < MAX_BYTES)) begin
        bytes_o[p*8 +: 8] = data_i[rel*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/segwr_lane.sv
// One segment command holding register with its own valid/ready handshake.
module segwr_lane #(
  parameter int SEG_BYTES = 4,
  parameter int SEG_AW    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   load_i,
  input  logic [SEG_AW-1:0]      addr_i,
  input  logic [SEG_BYTES*8-1:0] data_i,
  input  logic [SEG_BYTES-1:0]   be_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output logic [SEG_AW-1:0]      addr_o,
  output logic [SEG_BYTES*8-1:0] data_o,
  output logic [SEG_BYTES-1:0]   be_o,
  output logic                   free_o
);

  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      be_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
      be_o    <= be_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/segwr_top.sv
// Splits one byte-addressed write into rotating per-segment word writes.
// SEGS and SEG_BYTES are powers of two, each at least 2.
module segwr_top
  import segwr_pkg::*;
#(
  parameter int  SEGS      = 2,
  parameter int  SEG_BYTES = 4,
  parameter int  SEG_AW    = 4,
  parameter int  MAX_BYTES = 16,
  localparam int ADDR_W    = SEG_AW + $clog2(SEGS * SEG_BYTES),
  localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [LEN_W-1:0]            req_len_i,
  input  logic [MAX_BYTES*8-1:0]      req_data_i,
  output logic                        done_o,
  output logic                        err_o,
  output logic [SEGS-1:0]             cmd_valid_o,
  input  logic [SEGS-1:0]             cmd_ready_i,
  output logic [SEGS*SEG_AW-1:0]      cmd_addr_o,
  output logic [SEGS*SEG_BYTES*8-1:0] cmd_data_o,
  output logic [SEGS*SEG_BYTES-1:0]   cmd_be_o,
  input  logic [SEGS-1:0]             wr_done_i
);

  localparam int OFF_W    = $clog2(SEG_BYTES);
  localparam int SEG_W    = $clog2(SEGS);
  localparam int IDX_W    = ADDR_W - OFF_W;
  localparam int NBEATS   = (MAX_BYTES + 2 * SEG_BYTES - 2) / SEG_BYTES;
  localparam int BEAT_W   = $clog2(NBEATS + 1);
  localparam int LANE_DW  = SEG_BYTES * 8;
  localparam int STREAM_B = NBEATS * SEG_BYTES;

  segwr_state_e          state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [BEAT_W-1:0]     beat_q, total_q, cnt_q;
  logic [STREAM_B*8-1:0] stream_q, stream_d;
  logic [STREAM_B-1:0]   mask_q, mask_d;

  logic [OFF_W-1:0]      off_d;
  logic                  range_ok, fire, issue;
  logic [BEAT_W-1:0]     total_d, cnt_next, beat_sel;
  logic [SEG_W-1:0]      cur_seg;
  logic [SEGS-1:0]       lane_free, lane_load;
  logic [SEG_AW-1:0]     lane_addr;
  logic [LANE_DW-1:0]    lane_data;
  logic [SEG_BYTES-1:0]  lane_be;

  assign off_d       = req_addr_i[OFF_W-1:0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign fire        = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    range_ok = (req_len_i != '0) && (int'(req_len_i) <= MAX_BYTES) &&
               ((int'(req_addr_i) + int'(req_len_i)) <= (1 << ADDR_W));
    total_d  = BEAT_W'((int'(req_len_i) + int'(off_d) + SEG_BYTES - 1) / SEG_BYTES);
  end

  segwr_align #(
    .MAX_BYTES(MAX_BYTES),
    .STREAM_B (STREAM_B),
    .OFF_W    (OFF_W),
    .LEN_W    (LEN_W)
  ) u_align (
    .data_i (req_data_i),
    .off_i  (off_d),
    .len_i  (req_len_i),
    .bytes_o(stream_d),
    .mask_o (mask_d)
  );

  // Word being issued: segment from the low index bits, row from the rest.
  always_comb begin
    beat_sel  = (beat_q < BEAT_W'(NBEATS)) ? beat_q : '0;
    lane_data = stream_q[int'(beat_sel)*LANE_DW +: LANE_DW];
    lane_be   = mask_q[int'(beat_sel)*SEG_BYTES +: SEG_BYTES];
    lane_addr = idx_q[IDX_W-1:SEG_W];
    cur_seg   = idx_q[SEG_W-1:0];
    issue     = (state_q == ST_BUSY) && (beat_q < total_q) && lane_free[cur_seg];
    cnt_next  = cnt_q + BEAT_W'($countones(wr_done_i));
  end

  for (genvar s = 0; s < SEGS; s++) begin : g_lane
    assign lane_load[s] = issue && (cur_seg == SEG_W'(s));

    segwr_lane #(
      .SEG_BYTES(SEG_BYTES),
      .SEG_AW   (SEG_AW)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (lane_load[s]),
      .addr_i (lane_addr),
      .data_i (lane_data),
      .be_i   (lane_be),
      .ready_i(cmd_ready_i[s]),
      .valid_o(cmd_valid_o[s]),
      .addr_o (cmd_addr_o[s*SEG_AW +: SEG_AW]),
      .data_o (cmd_data_o[s*LANE_DW +: LANE_DW]),
      .be_o   (cmd_be_o[s*SEG_BYTES +: SEG_BYTES]),
      .free_o (lane_free[s])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      beat_q   <= '0;
      total_q  <= '0;
      cnt_q    <= '0;
      stream_q <= '0;
      mask_q   <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fire) begin
            if (range_ok) begin
              state_q  <= ST_BUSY;
              idx_q    <= req_addr_i[ADDR_W-1:OFF_W];
              beat_q   <= '0;
              total_q  <= total_d;
              cnt_q    <= '0;
              stream_q <= stream_d;
              mask_q   <= mask_d;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        default: begin
          if (issue) begin
            beat_q <= beat_q + 1'b1;
            idx_q  <= idx_q + 1'b1;
          end
          cnt_q <= cnt_next;
          if (cnt_next == total_q) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/segwr_chk.sv
module segwr_chk #(
  parameter int SEGS      = 2,
  parameter int SEG_BYTES = 4,
  parameter int SEG_AW    = 4
) (
  input logic                        clk_i,
  input logic                        rst_i,
  input logic                        req_ready_o,
  input logic                        done_o,
  input logic                        err_o,
  input logic [SEGS-1:0]             cmd_valid_o,
  input logic [SEGS-1:0]             cmd_ready_i,
  input logic [SEGS*SEG_AW-1:0]      cmd_addr_o,
  input logic [SEGS*SEG_BYTES*8-1:0] cmd_data_o,
  input logic [SEGS*SEG_BYTES-1:0]   cmd_be_o
);

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (cmd_valid_o == '0) && !done_o && !err_o);

  // R1
  idle_no_pending_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    req_ready_o |-> (cmd_valid_o == '0));

  // R8
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> req_ready_o && !err_o);

  // R2
  err_no_cmd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> req_ready_o && (cmd_valid_o == '0));

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    // R7
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_valid_o[s] && !cmd_ready_i[s]) |=>
        cmd_valid_o[s] &&
        $stable(cmd_addr_o[s*SEG_AW +: SEG_AW]) &&
        $stable(cmd_data_o[s*SEG_BYTES*8 +: SEG_BYTES*8]) &&
        $stable(cmd_be_o[s*SEG_BYTES +: SEG_BYTES]));

    // R5
    be_nonempty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cmd_valid_o[s] |-> (cmd_be_o[s*SEG_BYTES +: SEG_BYTES] != '0));
  end

endmodule

bind segwr_top segwr_chk #(
  .SEGS     (SEGS),
  .SEG_BYTES(SEG_BYTES),
  .SEG_AW   (SEG_AW)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_addr_o (cmd_addr_o),
  .cmd_data_o (cmd_data_o),
  .cmd_be_o   (cmd_be_o)
);

// File: tb/segwr_top_test.sv
`timescale 1ns/1ps
module segwr_top_test;

  localparam int SEGS = 2;
  localparam int SB   = 4;
  localparam int SAW  = 4;
  localparam int MAXB = 16;
  localparam int AW   = 7;
  localparam int LW   = 5;
  localparam int MEMB = 128;

  typedef struct packed {
    logic [SAW-1:0]  a;
    logic [SB-1:0]   be;
    logic [SB*8-1:0] d;
  } item_t;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic [AW-1:0]          req_addr = '0;
  logic [LW-1:0]          req_len = '0;
  logic [MAXB*8-1:0]      req_data = '0;
  logic                   done, err;
  logic [SEGS-1:0]        cmd_valid;
  logic [SEGS-1:0]        cmd_ready = '0;
  logic [SEGS*SAW-1:0]    cmd_addr;
  logic [SEGS*SB*8-1:0]   cmd_data;
  logic [SEGS*SB-1:0]     cmd_be;
  logic [SEGS-1:0]        wr_done = '0;

  int checks = 0;
  int fails = 0;
  int sent_dones = 0;
  bit stall_mode = 0;
  int tagc = 0;
  item_t q0[$];
  item_t q1[$];
  logic [7:0] ram [MEMB];
  logic [7:0] expmem [MEMB];

  always #10 clk = ~clk;

  segwr_top #(.SEGS(SEGS), .SEG_BYTES(SB), .SEG_AW(SAW), .MAX_BYTES(MAXB)) uut (
    .clk_i(clk), .rst_i(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_data_i(req_data),
    .done_o(done), .err_o(err),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .cmd_be_o(cmd_be),
    .wr_done_i(wr_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // RAM model and scoreboard monitor, all at the falling edge
  initial begin
    logic [SEGS-1:0] pend;
    logic [SEGS-1:0] was_stall;
    item_t held [SEGS];
    pend = '0;
    was_stall = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        cmd_ready = '0;
        wr_done = '0;
        pend = '0;
        was_stall = '0;
      end else begin
        wr_done = pend;
        for (int s = 0; s < SEGS; s++) if (wr_done[s]) sent_dones++;
        for (int s = 0; s < SEGS; s++) begin
          item_t cur;
          item_t exp;
          cur.a  = cmd_addr[s*SAW +: SAW];
          cur.be = cmd_be[s*SB +: SB];
          cur.d  = cmd_data[s*SB*8 +: SB*8];
          if (was_stall[s]) begin
            // R7: a stalled command keeps every field
            chk(cmd_valid[s] && (cur == held[s]), "R7", "stalled command changed",
                64'(cur), 64'(held[s]));
          end
          cmd_ready[s] = stall_mode ? (($urandom % 3) != 0) : 1'b1;
          pend[s] = cmd_valid[s] && cmd_ready[s];
          was_stall[s] = cmd_valid[s] && !cmd_ready[s];
          held[s] = cur;
          if (pend[s]) begin
            bit empty;
            empty = (s == 0) ? (q0.size() == 0) : (q1.size() == 0);
            // R3: a command in a segment that expects none is a rotation error
            chk(!empty, "R3", "unexpected command in segment", 64'(s), 64'(0));
            if (!empty) begin
              exp = (s == 0) ? q0.pop_front() : q1.pop_front();
              chk(cur.a == exp.a, "R4", "word address", 64'(cur.a), 64'(exp.a));
              chk(cur.be == exp.be, "R5", "byte enables", 64'(cur.be), 64'(exp.be));
              for (int b = 0; b < SB; b++) begin
                if (exp.be[b] && (cur.d[b*8 +: 8] != exp.d[b*8 +: 8])) begin
                  chk(1'b0, "R6", "lane data", 64'(cur.d), 64'(exp.d));
                  break;
                end
              end
            end
            for (int b = 0; b < SB; b++)
              if (cur.be[b]) ram[(int'(cur.a) * SEGS + s) * SB + b] = cur.d[b*8 +: 8];
          end
        end
      end
    end
  end

  // Driver: builds the expected commands, then presents the request
  task automatic do_req(input int addr, input int len, input bit exp_err);
    int off;
    int nb;
    bit seen;
    tagc++;
    for (int j = 0; j < MAXB; j++) req_data[j*8 +: 8] = 8'(addr * 3 + j * 29 + tagc * 11);
    off = addr % SB;
    nb = (len + off + SB - 1) / SB;
    if (!exp_err) begin
      for (int k = 0; k < nb; k++) begin
        item_t it;
        int idx;
        idx = addr / SB + k;
        it.a = SAW'(idx / SEGS);
        it.be = '0;
        it.d = '0;
        for (int b = 0; b < SB; b++) begin
          int j;
          j = k * SB + b - off;
          if (j >= 0 && j < len) begin
            it.be[b] = 1'b1;
            it.d[b*8 +: 8] = req_data[j*8 +: 8];
            expmem[addr + j] = req_data[j*8 +: 8];
          end
        end
        if ((idx % SEGS) == 0) q0.push_back(it);
        else q1.push_back(it);
      end
    end
    sent_dones = 0;
    @(negedge clk);
    req_addr = AW'(addr);
    req_len = LW'(len);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_err) begin
      chk(err == 1'b1, "R2", "error pulse after bad request", 64'(err), 64'(1));
      seen = 0;
      for (int c = 0; c < 6; c++) begin
        if (cmd_valid != '0) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R2", "command issued for rejected request", 64'(seen), 64'(0));
      chk(req_ready == 1'b1, "R1", "ready after rejection", 64'(req_ready), 64'(1));
    end else begin
      chk(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'(0));
      chk(err == 1'b0, "R2", "error on valid request", 64'(err), 64'(0));
      seen = 0;
      for (int c = 0; c < 400; c++) begin
        if (done) begin
          seen = 1;
          break;
        end
        @(negedge clk);
      end
      chk(seen && (sent_dones == nb), "R8", "completion vs confirms sent",
          64'(sent_dones), 64'(nb));
      chk((q0.size() == 0) && (q1.size() == 0), "R3", "writes left unissued",
          64'(q0.size() + q1.size()), 64'(0));
      chk(req_ready == 1'b1, "R1", "ready with completion", 64'(req_ready), 64'(1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int mism;
    for (int i = 0; i < MEMB; i++) begin
      ram[i] = 8'(i * 5 + 1);
      expmem[i] = 8'(i * 5 + 1);
    end
    repeat (3) @(negedge clk);
    // R9
    chk(cmd_valid == '0 && !done && !err, "R9", "outputs during reset",
        64'({cmd_valid, done, err}), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", 64'(req_ready), 64'(1));

    do_req(0, 8, 0);      // aligned, two segments
    do_req(5, 3, 0);      // single write, first-lane limit
    do_req(2, 1, 0);      // single byte, both limits
    do_req(13, 16, 0);    // starts in segment 1, five writes
    do_req(60, 7, 0);     // crosses a row boundary
    do_req(112, 16, 0);   // ends exactly at the top of the space
    do_req(127, 1, 0);    // last byte
    do_req(120, 9, 1);    // runs past the end
    do_req(0, 0, 1);      // zero length
    do_req(4, 17, 1);     // longer than the data field
    stall_mode = 1;
    for (int i = 0; i < 24; i++) do_req((i * 37) % 113, 1 + (i * 7) % 16, 0);
    do_req(31, 16, 0);
    stall_mode = 0;
    do_req(3, 2, 0);

    repeat (4) @(negedge clk);
    mism = -1;
    for (int i = 0; i < MEMB; i++) if (ram[i] !== expmem[i] && mism < 0) mism = i;
    chk(mism < 0, "R6", "memory image, first bad byte index", 64'(mism), 64'(-1));
    summary();
    $finish;
  end

endmodule